// File: doc/BRIEF.md
# Interleaved Signed Multiply-Accumulate Unit

This block is a pipelined multiply-accumulate engine that holds eight separate accumulators, called contexts, and shares one multiplier among them. Each operation names a context and two word-wide operands. The engine computes a signed product, or passes one operand straight through, and folds the result into that context's wide accumulator. The operations are multiply-add, multiply-subtract, add, subtract, clear, load and shift-out. Operations from different contexts can be issued on consecutive cycles, so with a round-robin issue order eight independent sums move through the pipeline at once.

The multiplier is one bit wider than the data word and signed. A per-operation flag picks sign extension or zero extension of both operands, so one datapath serves signed and unsigned arithmetic. The product is built as one partial-product row per multiplier bit. A carry-save tree of 3:2 compressors reduces the rows to a sum/carry pair, and one carry-propagate add closes them. The accumulator is wider than a product. The shift-out operation returns the low word and shifts the accumulator down one word arithmetically, which is the step that column-wise (product-scanning) multi-word multiplication needs.

Top module: `smac_engine`

## Requirements
- R1: The eight contexts are independent: an operation changes only the accumulator named by its `issueCtx`.
- R2: Op code 1 (multiply-add) sets acc = acc + A*B. When `opSigned` is 1 both operands are two's complement; when it is 0 both are unsigned.
- R3: Op code 7 (multiply-subtract) sets acc = acc - A*B, with the same operand extension as R2.
- R4: Op code 2 sets acc = acc + A and op code 3 sets acc = acc - A, with A extended according to `opSigned`. `opB` has no effect on either.
- R5: Op code 4 clears the accumulator to zero, and the result word is zero.
- R6: Op code 5 loads the accumulator with A extended according to `opSigned`, and the result word equals A.
- R7: Op code 6 returns the low word of the accumulator as it was before the operation, then shifts the accumulator right by one word with sign fill.
- R8: For every op code except 6, the result word is the low word of the updated accumulator.
- R9: An operation accepted on a rising edge has its result registered on the third rising edge after that one, with `resValid` high and `resCtx` equal to the issued context. Results leave in issue order, and one operation can be accepted on every cycle.
- R10: Operations on the same context may be issued back to back, and each one sees the accumulator left by the one before it.
- R11: Op code 0, or `issueValid` low, produces no result and changes no accumulator.
- R12: While `rstN` is low, `resValid` is low and all accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An operation is offered this cycle |
| issueOp | input | 3 | Op code (0 none, 1 mul-add, 2 add, 3 sub, 4 clear, 5 load, 6 shift-out, 7 mul-sub) |
| issueCtx | input | 3 | Context (accumulator) index |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand (multiplier input) |
| opSigned | input | 1 | 1: operands are two's complement; 0: unsigned |
| resValid | output | 1 | Result word is valid |
| resCtx | output | 3 | Context the result belongs to |
| resWord | output | DATA_W | Result word |

## Verification
On every cycle the assertions check the fixed issue-to-result timing and the context tag of each result. They also check two operations whose result word depends only on the issued operands: clear and load. The arithmetic itself can only be shown by the scenarios. The bench keeps its own model of all eight accumulators and compares each result word. This covers signed and unsigned products at the operand extremes, multiply-subtract, add and subtract against a random `opB`, dependent operations on one context back to back, and a shift-out chain that reaches the sign-filled top of the accumulator.

// File: rtl/smac_pkg.sv
package smac_pkg;
  localparam int NUM_CTX = 8;
  localparam int CTX_W = $clog2(NUM_CTX);

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_MADD  = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_CLR   = 3'd4,
    OP_LOAD  = 3'd5,
    OP_SHIFT = 3'd6,
    OP_MSUB  = 3'd7
  } op_e;

  // strobes consumed at the product-closing stage
  typedef struct packed {
    logic useMul;
    logic negate;
  } mulCtl_t;

  // strobes consumed at the accumulator write-back stage
  typedef struct packed {
    logic             valid;
    logic             clr;
    logic             load;
    logic             shift;
    logic [CTX_W-1:0] ctx;
  } wbCtl_t;
endpackage

// File: rtl/smac_csa.sv
module smac_csa #(
  parameter int W   = 66,
  parameter int NIN = 34
) (
  input  logic [W-1:0] rows [NIN],
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);
  localparam int NGRP  = (NIN + 2) / 3;
  localparam int NPAD  = 3 * NGRP;
  localparam int IDX_W = $clog2(NPAD + 1);
  localparam int NLVL  = 2 * $clog2(NIN + 1) + 2;

  logic [W-1:0] cur [NPAD];
  logic [W-1:0] nxt [NPAD];

  always_comb begin
    int n;
    int m;
    for (int r = 0; r < NPAD; r++) cur[r] = (r < NIN) ? rows[r] : '0;
    for (int r = 0; r < NPAD; r++) nxt[r] = '0;
    n = NIN;
    for (int lvl = 0; lvl < NLVL; lvl++) begin
      if (n > 2) begin
        for (int r = 0; r < NPAD; r++) nxt[r] = '0;
        m = 0;
        for (int k = 0; k < NGRP; k++) begin
          if (3 * k + 2 < n) begin
            nxt[IDX_W'(m)]     = cur[3*k] ^ cur[3*k+1] ^ cur[3*k+2];
            nxt[IDX_W'(m + 1)] = ((cur[3*k] & cur[3*k+1]) | (cur[3*k] & cur[3*k+2]) |
                                  (cur[3*k+1] & cur[3*k+2])) << 1;
            m = m + 2;
          end else if (3 * k + 1 < n) begin
            nxt[IDX_W'(m)]     = cur[3*k];
            nxt[IDX_W'(m + 1)] = cur[3*k+1];
            m = m + 2;
          end else if (3 * k < n) begin
            nxt[IDX_W'(m)] = cur[3*k];
            m = m + 1;
          end
        end
        cur = nxt;
        n = m;
      end
    end
    sumOut   = cur[0];
    carryOut = cur[1];
  end
endmodule

// File: rtl/smac_ctrl.sv
module smac_ctrl
  import smac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [2:0]       issueOp,
  input  logic [CTX_W-1:0] issueCtx,
  output mulCtl_t          s2Mul,
  output wbCtl_t           s3Wb,
  output logic             resValid,
  output logic [CTX_W-1:0] resCtx
);
  op_e     op;
  mulCtl_t decMul, s1Mul;
  wbCtl_t  decWb, s1Wb, s2Wb;

  always_comb begin
    op           = op_e'(issueOp);
    decMul.useMul = (op == OP_MADD) || (op == OP_MSUB);
    decMul.negate = (op == OP_SUB) || (op == OP_MSUB);
    decWb.valid  = issueValid && (op != OP_NONE);
    decWb.clr    = (op == OP_CLR);
    decWb.load   = (op == OP_LOAD);
    decWb.shift  = (op == OP_SHIFT);
    decWb.ctx    = issueCtx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Mul    <= '0;
      s2Mul    <= '0;
      s1Wb     <= '0;
      s2Wb     <= '0;
      s3Wb     <= '0;
      resValid <= 1'b0;
      resCtx   <= '0;
    end else begin
      s1Mul    <= decMul;
      s2Mul    <= s1Mul;
      s1Wb     <= decWb;
      s2Wb     <= s1Wb;
      s3Wb     <= s2Wb;
      resValid <= s3Wb.valid;
      resCtx   <= s3Wb.ctx;
    end
  end
endmodule

// File: rtl/smac_dp.sv
module smac_dp
  import smac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              opSigned,
  input  mulCtl_t           s2Mul,
  input  wbCtl_t            s3Wb,
  output logic [DATA_W-1:0] resWord
);
  localparam int MULT_W = DATA_W + 1;
  localparam int PROD_W = 2 * MULT_W;
  localparam int NROW   = MULT_W + 1;

  // stage 1: extended operands
  logic [MULT_W-1:0] s1A, s1B;
  // stage 2: carry-save product plus pass-through operand
  logic [PROD_W-1:0] s2Sum, s2Carry;
  logic [MULT_W-1:0] s2A;
  // stage 3: signed addend for the accumulator
  logic [ACC_W-1:0]  s3Term;

  logic [ACC_W-1:0]  accFile [NUM_CTX];

  logic [PROD_W-1:0] aWide;
  logic [PROD_W-1:0] ppRow [NROW];
  logic [PROD_W-1:0] csaSum, csaCarry;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  base, term;
  logic [ACC_W-1:0]  curAcc, addAcc, shAcc, nextAcc;

  // one row per multiplier bit; the top bit carries negative weight
  always_comb begin
    aWide = PROD_W'(signed'(s1A));
    for (int j = 0; j < MULT_W - 1; j++)
      ppRow[j] = s1B[j] ? (aWide << j) : '0;
    ppRow[MULT_W-1] = s1B[MULT_W-1] ? ~(aWide << (MULT_W - 1)) : '0;
    ppRow[MULT_W]   = PROD_W'(s1B[MULT_W-1]);
  end

  smac_csa #(.W(PROD_W), .NIN(NROW)) u_csa (
    .rows    (ppRow),
    .sumOut  (csaSum),
    .carryOut(csaCarry)
  );

  always_comb begin
    prod = s2Sum + s2Carry;
    base = s2Mul.useMul ? ACC_W'(signed'(prod)) : ACC_W'(signed'(s2A));
    term = s2Mul.negate ? (~base + 1'b1) : base;
  end

  always_comb begin
    curAcc = accFile[s3Wb.ctx];
    addAcc = curAcc + s3Term;
    shAcc  = $signed(curAcc) >>> DATA_W;
    if (s3Wb.clr)        nextAcc = '0;
    else if (s3Wb.load)  nextAcc = s3Term;
    else if (s3Wb.shift) nextAcc = shAcc;
    else                 nextAcc = addAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1A     <= '0;
      s1B     <= '0;
      s2Sum   <= '0;
      s2Carry <= '0;
      s2A     <= '0;
      s3Term  <= '0;
      resWord <= '0;
      for (int c = 0; c < NUM_CTX; c++) accFile[c] <= '0;
    end else begin
      s1A     <= {opSigned & opA[DATA_W-1], opA};
      s1B     <= {opSigned & opB[DATA_W-1], opB};
      s2Sum   <= csaSum;
      s2Carry <= csaCarry;
      s2A     <= s1A;
      s3Term  <= term;
      if (s3Wb.valid) begin
        accFile[s3Wb.ctx] <= nextAcc;
        resWord <= s3Wb.shift ? curAcc[DATA_W-1:0] : nextAcc[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/smac_engine.sv
module smac_engine
  import smac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [2:0]        issueOp,
  input  logic [CTX_W-1:0]  issueCtx,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              opSigned,
  output logic              resValid,
  output logic [CTX_W-1:0]  resCtx,
  output logic [DATA_W-1:0] resWord
);
  mulCtl_t s2Mul;
  wbCtl_t  s3Wb;

  smac_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .issueOp   (issueOp),
    .issueCtx  (issueCtx),
    .s2Mul     (s2Mul),
    .s3Wb      (s3Wb),
    .resValid  (resValid),
    .resCtx    (resCtx)
  );

  smac_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .opSigned(opSigned),
    .s2Mul   (s2Mul),
    .s3Wb    (s3Wb),
    .resWord (resWord)
  );
endmodule

// File: rtl/smac_engine_chk.sv
module smac_engine_chk
  import smac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [2:0]        issueOp,
  input logic [CTX_W-1:0]  issueCtx,
  input logic [DATA_W-1:0] opA,
  input logic              resValid,
  input logic [CTX_W-1:0]  resCtx,
  input logic [DATA_W-1:0] resWord
);
  logic [2:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd4) sinceRst <= sinceRst + 3'd1;
  end
  assign warm = (sinceRst == 3'd4);

  // R12
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!resValid);
    end
  end

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (resValid == $past(issueValid && (issueOp != 3'd0), 4)));

  // R9
  result_ctx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && resValid) |-> (resCtx == $past(issueCtx, 4)));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && resValid && ($past(issueOp, 4) == 3'd4)) |-> (resWord == '0));

  // R6
  load_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && resValid && ($past(issueOp, 4) == 3'd5)) |-> (resWord == $past(opA, 4)));
endmodule

bind smac_engine smac_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .issueOp   (issueOp),
  .issueCtx  (issueCtx),
  .opA       (opA),
  .resValid  (resValid),
  .resCtx    (resCtx),
  .resWord   (resWord)
);

// File: tb/smac_engine_test.sv
module smac_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 70;
  localparam logic [2:0] NONE = 3'd0, MADD = 3'd1, ADD = 3'd2, SUB = 3'd3,
                         CLR = 3'd4, LOAD = 3'd5, SHF = 3'd6, MSUB = 3'd7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic [2:0]    issueOp = '0;
  logic [2:0]    issueCtx = '0;
  logic [DW-1:0] opA = '0, opB = '0;
  logic          opSigned = 1'b0;
  logic          resValid;
  logic [2:0]    resCtx;
  logic [DW-1:0] resWord;

  smac_engine #(.DATA_W(DW), .ACC_W(AW)) uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueCtx(issueCtx), .opA(opA), .opB(opB), .opSigned(opSigned),
    .resValid(resValid), .resCtx(resCtx), .resWord(resWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0, nBad = 0, cyc = 0;
  logic signed [AW-1:0] model [8];
  int            ctxQ[$];
  logic [DW-1:0] wordQ[$];
  int            cycQ[$];
  string         reqQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  // result monitor: order, context, word and timing (R9)
  always @(negedge clk) begin
    if (rstN && resValid) begin
      nCmp++;
      if (ctxQ.size() == 0) begin
        nBad++;
        $display("FAIL R11: unexpected result ctx %0d word %h, expected none", resCtx, resWord);
      end else begin
        int ec, ecy;
        logic [DW-1:0] ew;
        string rq;
        ec = ctxQ.pop_front(); ew = wordQ.pop_front();
        ecy = cycQ.pop_front(); rq = reqQ.pop_front();
        if (resCtx !== 3'(ec) || resWord !== ew || cyc != ecy) begin
          nBad++;
          $display("FAIL %s/R9: ctx %0d word %h cycle %0d, expected ctx %0d word %h cycle %0d",
                   rq, resCtx, resWord, cyc, ec, ew, ecy);
        end
      end
    end
  end

  task automatic issue(input logic [2:0] op, input int c, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic sg, input string rq);
    logic signed [AW-1:0] ea, eb, old;
    logic [DW-1:0] w;
    @(negedge clk);
    issueValid = 1'b1; issueOp = op; issueCtx = 3'(c);
    opA = a; opB = b; opSigned = sg;
    ea = sg ? AW'($signed(a)) : AW'(a);
    eb = sg ? AW'($signed(b)) : AW'(b);
    old = model[c];
    case (op)
      MADD:  model[c] = old + ea * eb;
      MSUB:  model[c] = old - ea * eb;
      ADD:   model[c] = old + ea;
      SUB:   model[c] = old - ea;
      CLR:   model[c] = '0;
      LOAD:  model[c] = ea;
      SHF:   model[c] = old >>> DW;
      default: ;
    endcase
    w = (op == SHF) ? old[DW-1:0] : model[c][DW-1:0];
    if (op != NONE) begin
      ctxQ.push_back(c); wordQ.push_back(w);
      cycQ.push_back(cyc + 4); reqQ.push_back(rq);
    end
  endtask

  task automatic idleDrain();
    @(negedge clk);
    issueValid = 1'b0; issueOp = NONE;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom);
  endfunction

  // R12: quiet outputs and zeroed accumulators after reset
  task automatic testReset();
    nCmp++;
    if (resValid !== 1'b0) begin
      nBad++; $display("FAIL R12: resValid %b during reset, expected 0", resValid);
    end
    rstN = 1'b1;
    for (int c = 0; c < 8; c++) issue(ADD, c, '0, rnd(), 1'b0, "R12");
    idleDrain();
  endtask

  // R2, R1: unsigned and signed products, contexts in round-robin
  task automatic testMadd();
    for (int c = 0; c < 8; c++) issue(CLR, c, '0, '0, 1'b0, "R5");
    for (int rnd_i = 0; rnd_i < 6; rnd_i++)
      for (int c = 0; c < 8; c++) issue(MADD, c, rnd(), rnd(), c[0], "R2");
    issue(MADD, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R2");
    issue(MADD, 1, 32'h8000_0000, 32'h8000_0000, 1'b1, "R2");
    issue(MADD, 2, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R2");
    issue(MADD, 3, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R2");
    for (int c = 0; c < 8; c++) issue(ADD, c, '0, '0, 1'b0, "R1");
    idleDrain();
  endtask

  // R3: multiply-subtract
  task automatic testMsub();
    for (int c = 0; c < 8; c++) issue(MSUB, c, rnd(), rnd(), c[1], "R3");
    issue(MSUB, 4, 32'h8000_0000, 32'h8000_0000, 1'b1, "R3");
    issue(MSUB, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3");
    idleDrain();
  endtask

  // R4: add and subtract with opB driven at random
  task automatic testAddSub();
    for (int c = 0; c < 8; c++) issue(LOAD, c, '0, rnd(), 1'b0, "R6");
    for (int c = 0; c < 8; c++) issue(ADD, c, rnd(), rnd(), c[2], "R4");
    for (int c = 0; c < 8; c++) issue(SUB, c, rnd(), rnd(), c[0], "R4");
    issue(SUB, 3, 32'hFFFF_FFFF, rnd(), 1'b0, "R4");
    issue(ADD, 3, 32'h8000_0000, rnd(), 1'b1, "R4");
    idleDrain();
  endtask

  // R5, R6: clear and load, signed and unsigned
  task automatic testClearLoad();
    issue(LOAD, 6, 32'h8000_0001, rnd(), 1'b1, "R6");
    issue(LOAD, 7, 32'h8000_0001, rnd(), 1'b0, "R6");
    issue(ADD, 6, '0, '0, 1'b0, "R8");
    issue(SHF, 6, '0, '0, 1'b0, "R7");
    issue(SHF, 7, '0, '0, 1'b0, "R7");
    issue(CLR, 6, rnd(), rnd(), 1'b1, "R5");
    issue(ADD, 6, '0, '0, 1'b0, "R5");
    idleDrain();
  endtask

  // R7, R8: product-scanning shift-out down to the sign-filled top
  task automatic testShift();
    issue(CLR, 2, '0, '0, 1'b0, "R5");
    issue(MADD, 2, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R8");
    issue(MSUB, 2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R8");
    issue(SHF, 2, '0, '0, 1'b0, "R7");
    issue(SHF, 2, '0, '0, 1'b0, "R7");
    issue(SHF, 2, '0, '0, 1'b0, "R7");
    issue(SHF, 2, '0, '0, 1'b0, "R7");
    issue(MADD, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8");
    issue(SHF, 5, '0, '0, 1'b0, "R7");
    issue(SHF, 5, '0, '0, 1'b0, "R7");
    issue(SHF, 5, '0, '0, 1'b0, "R7");
    idleDrain();
  endtask

  // R10: dependent ops on one context every cycle
  task automatic testBackToBack();
    issue(LOAD, 1, 32'h0000_0010, '0, 1'b0, "R10");
    issue(MADD, 1, 32'h0001_0000, 32'h0001_0000, 1'b0, "R10");
    issue(SUB, 1, 32'h0000_0001, '0, 1'b0, "R10");
    issue(SHF, 1, '0, '0, 1'b0, "R10");
    issue(MADD, 1, rnd(), rnd(), 1'b1, "R10");
    issue(MSUB, 1, rnd(), rnd(), 1'b1, "R10");
    issue(ADD, 1, rnd(), '0, 1'b1, "R10");
    idleDrain();
  endtask

  // R11: op 0 and invalid cycles leave no trace
  task automatic testNone();
    issue(LOAD, 0, 32'h1234_5678, '0, 1'b0, "R6");
    issue(NONE, 0, rnd(), rnd(), 1'b1, "R11");
    @(negedge clk);
    issueValid = 1'b0; issueOp = MADD; issueCtx = 3'd0; opA = rnd(); opB = rnd();
    @(negedge clk);
    issueOp = CLR;
    repeat (6) @(negedge clk);
    issue(ADD, 0, '0, '0, 1'b0, "R11");
    idleDrain();
  endtask

  initial begin
    for (int c = 0; c < 8; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    testReset();
    testMadd();
    testMsub();
    testAddSub();
    testClearLoad();
    testShift();
    testBackToBack();
    testNone();
    repeat (4) @(negedge clk);
    nCmp++;
    if (ctxQ.size() != 0) begin
      nBad++; $display("FAIL R9: %0d results missing, expected 0", ctxQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nCmp++; nBad++;
    $display("FAIL R9: watchdog expired, got hang, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule